// File: doc/BRIEF.md
# Frequency Lock Detector with Loop-Mode Select

This block decides whether a clock-recovery loop has reached frequency lock. It watches two clocks: a local reference clock and the recovered clock after division by twenty. At the nominal rate the two run one-for-one. The block counts divided recovered-clock edges over back-to-back measurement windows of a fixed number of reference cycles. It then compares each count with the window length, using a tolerance chosen by a select input. The narrow setting is roughly ±500 ppm and the wide setting roughly ±2000 ppm.

Two outputs follow from these window verdicts. The first is a lock status flag. The second is a loop-mode select. While the loop is unlocked, the mode select keeps the charge pump on the phase-frequency comparator, which works against the reference. Once lock is declared, it hands the charge pump to the data phase detector. Measurement keeps running after lock, so a single bad window sends the loop back to reference-based acquisition.

The recovered-clock count is kept in its own clock domain as a Gray-coded counter. The reference domain reads it through a synchronizer chain. A recovered clock that has stopped gives a zero count and is treated like any other frequency error.

Top module: `freq_lock_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `lock` is 0 and `track_sel` is 0 (reference acquisition), until a window verdict changes them.
- R2: A measurement window lasts 2^WIN_LOG2 reference cycles. `lock` and `track_sel` change only on the reference edge that ends a window. Counting from the first edge after reset release as edge 1, these are edges k·2^WIN_LOG2.
- R3: The recovered-clock edge count crosses into the reference domain only as a Gray code. Between any two consecutive recovered-clock edges, at most one bit of it changes.
- R4: A window is in range when its count differs from 2^WIN_LOG2 by no more than the tolerance. The tolerance is TOL_NARROW when `wide_tol` is 0 and TOL_WIDE when `wide_tol` is 1, with `wide_tol` sampled at the window's end.
- R5: `lock` rises only at the end of the second of two consecutive in-range windows.
- R6: One out-of-range window clears `lock` at that window's end and restarts the count of in-range windows.
- R7: `track_sel` equals `lock` at all times. A value of 1 selects the data phase detector and 0 selects the reference comparator.
- R8: A stopped recovered clock makes each affected window out of range.
- R9: The first window after reset has no baseline count and never counts as in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock; all decisions are made in this domain |
| rst_n | input | 1 | Active-low reset, synchronous to ref_clk, also clears the recovered-clock counter |
| rec_clk | input | 1 | Recovered clock after the divide-by-twenty |
| wide_tol | input | 1 | 0 selects the narrow tolerance, 1 selects the wide tolerance |
| lock | output | 1 | Frequency-lock status |
| track_sel | output | 1 | Loop-mode select: 1 selects the data phase detector, 0 selects the reference comparator |

## Verification
The hardest situations to reach are a recovered clock that stops entirely and a clock that resumes on a window boundary. In both, the synchronizer delay moves a few edges into the neighbouring window. The stimulus changes the recovered-clock period, or halts it, exactly at window boundaries. The chosen frequency offsets (0, about 1 % and about 3 %) fall well clear of both tolerance limits. As a result, the few edges that slip across a boundary cannot change any window's verdict, and the bench can predict every cycle of `lock` exactly. The sequence includes a restart after two stopped windows, using the wide tolerance so the edges lost to the pipeline stay inside the limit.

// File: rtl/flm_pkg.sv
package flm_pkg;

  localparam int unsigned FLM_MAX_W = 32;

  function automatic logic [FLM_MAX_W-1:0] flm_bin2gray(input logic [FLM_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [FLM_MAX_W-1:0] flm_gray2bin(input logic [FLM_MAX_W-1:0] g);
    logic [FLM_MAX_W-1:0] b;
    b[FLM_MAX_W-1] = g[FLM_MAX_W-1];
    for (int i = FLM_MAX_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // True when count lies within nominal +/- tol (inclusive).
  function automatic logic flm_within_tol(input int unsigned count,
                                          input int unsigned nominal,
                                          input int unsigned tol);
    int unsigned diff;
    diff = (count >= nominal) ? (count - nominal) : (nominal - count);
    return diff <= tol;
  endfunction

endpackage

// File: rtl/flm_rec_counter.sv
module flm_rec_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             rec_clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray_o
);
  import flm_pkg::*;

  logic [1:0]       rrst_sync;
  logic             rrst_n;
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_next;

  // Reset enters the recovered domain asynchronously and leaves it synchronously.
  always_ff @(posedge rec_clk or negedge rst_n) begin
    if (!rst_n) rrst_sync <= '0;
    else        rrst_sync <= {rrst_sync[0], 1'b1};
  end
  assign rrst_n = rrst_sync[1];

  assign bin_next = bin_q + 1'b1;

  always_ff @(posedge rec_clk or negedge rrst_n) begin
    if (!rrst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_next;
      gray_o <= CNT_W'(flm_bin2gray(FLM_MAX_W'(bin_next)));
    end
  end

  // R3: the crossing value moves by a single bit per recovered edge
  a_r3_gray_single_step: assert property (@(posedge rec_clk) disable iff (!rrst_n)
    $countones(gray_o ^ $past(gray_o)) <= 1);

endmodule

// File: rtl/flm_gray_sync.sv
module flm_gray_sync #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_i,
  output logic [CNT_W-1:0] bin_o
);
  import flm_pkg::*;

  logic [CNT_W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= gray_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign bin_o = CNT_W'(flm_gray2bin(FLM_MAX_W'(stage_q[STAGES-1])));

endmodule

// File: rtl/flm_window_timer.sv
module flm_window_timer #(
  parameter int unsigned WIN_LOG2 = 14
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  logic [WIN_LOG2-1:0] wcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) wcnt_q <= '0;
    else        wcnt_q <= wcnt_q + 1'b1;
  end

  assign tick_o = &wcnt_q;

  // R2: window ends are never on adjacent cycles
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/flm_lock_fsm.sv
module flm_lock_fsm #(
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned NOMINAL      = 16384,
  parameter int unsigned TOL_NARROW   = 8,
  parameter int unsigned TOL_WIDE     = 32,
  parameter int unsigned LOCK_WINDOWS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wide_tol_i,
  output logic             win_good_o,
  output logic             lock_o,
  output logic             track_o
);
  import flm_pkg::*;

  localparam int unsigned RUN_W = $clog2(LOCK_WINDOWS + 1);

  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] delta;
  logic             primed_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_next;
  logic             locked_q;
  int unsigned      tol_sel;

  assign delta    = count_i - prev_q;
  assign tol_sel  = wide_tol_i ? TOL_WIDE : TOL_NARROW;
  assign win_good_o = primed_q && flm_within_tol(32'(delta), NOMINAL, tol_sel);
  assign run_next = (32'(run_q) >= LOCK_WINDOWS) ? run_q : run_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      run_q    <= '0;
      locked_q <= 1'b0;
    end else if (tick_i) begin
      prev_q   <= count_i;
      primed_q <= 1'b1;
      if (win_good_o) begin
        run_q    <= run_next;
        locked_q <= (32'(run_next) >= LOCK_WINDOWS);
      end else begin
        run_q    <= '0;
        locked_q <= 1'b0;
      end
    end
  end

  assign lock_o  = locked_q;
  assign track_o = locked_q;

  // R2: outputs hold between window ends
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(lock_o) && $stable(track_o)));

  // R5: lock only rises after a good window verdict
  a_r5_rise_after_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(tick_i && win_good_o));

  // R6: one bad window drops lock
  a_r6_drop_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !win_good_o) |=> !lock_o);

  // R9: the baseline window never leads to lock
  a_r9_first_window: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !primed_q) |=> !lock_o);

endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor #(
  parameter int unsigned WIN_LOG2     = 14,
  parameter int unsigned TOL_NARROW   = 8,
  parameter int unsigned TOL_WIDE     = 32,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned LOCK_WINDOWS = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic rec_clk,
  input  logic wide_tol,
  output logic lock,
  output logic track_sel
);
  localparam int unsigned CNT_W   = WIN_LOG2 + 2;
  localparam int unsigned NOMINAL = 1 << WIN_LOG2;

  logic [CNT_W-1:0] rec_gray;
  logic [CNT_W-1:0] rec_count;
  logic             win_tick;
  logic             win_good;

  flm_rec_counter #(.CNT_W(CNT_W)) u_rec_cnt (
    .rec_clk (rec_clk),
    .rst_n   (rst_n),
    .gray_o  (rec_gray)
  );

  flm_gray_sync #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .gray_i (rec_gray),
    .bin_o  (rec_count)
  );

  flm_window_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .tick_o (win_tick)
  );

  flm_lock_fsm #(
    .CNT_W(CNT_W), .NOMINAL(NOMINAL), .TOL_NARROW(TOL_NARROW),
    .TOL_WIDE(TOL_WIDE), .LOCK_WINDOWS(LOCK_WINDOWS)
  ) u_fsm (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .tick_i     (win_tick),
    .count_i    (rec_count),
    .wide_tol_i (wide_tol),
    .win_good_o (win_good),
    .lock_o     (lock),
    .track_o    (track_sel)
  );

  // R1: nothing is locked while reset is held
  a_r1_reset_quiet: assert property (@(posedge ref_clk)
    !rst_n |=> (!lock && !track_sel));

endmodule

// File: tb/freq_lock_monitor_tb_top.sv
`timescale 1ns/1ps
module freq_lock_monitor_tb_top;

  localparam int WIN_LOG2 = 10;
  localparam int WIN      = 1 << WIN_LOG2;
  localparam int TOL_N    = 4;
  localparam int TOL_W    = 16;
  localparam int NWIN     = 15;

  logic ref_clk = 0;
  logic rec_clk = 0;
  logic rst_n   = 0;
  logic wide_tol = 0;
  logic lock, track_sel;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;
  int  rec_half_ps = 4000;   // 0 means stopped

  int    half_tab [NWIN];
  bit    wide_tab [NWIN];
  string req_tab  [NWIN];

  freq_lock_monitor #(.WIN_LOG2(WIN_LOG2), .TOL_NARROW(TOL_N), .TOL_WIDE(TOL_W)) dut_i (
    .ref_clk(ref_clk), .rst_n(rst_n), .rec_clk(rec_clk),
    .wide_tol(wide_tol), .lock(lock), .track_sel(track_sel)
  );

  always #4 ref_clk = ~ref_clk;

  initial begin
    #3;
    forever begin
      if (rec_half_ps == 0) begin
        rec_clk = 0;
        wait (rec_half_ps != 0);
      end else begin
        #(real'(rec_half_ps) / 1000.0) rec_clk = ~rec_clk;
      end
    end
  end

  task automatic check(input string req, input bit act, input bit exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural verdict: expected edges per window from the period ratio.
  function automatic bit model_in_range(input int half, input bit wide);
    real dev;
    if (half == 0) return 0;
    dev = real'(WIN) * (4000.0 / real'(half) - 1.0);
    if (dev < 0.0) dev = -dev;
    return dev <= real'(wide ? TOL_W : TOL_N);
  endfunction

  initial begin
    int run = 0;
    bit exp_lock = 0;
    int cyc = 0;
    int win = 0;
    // window settings: half period (ps), wide tolerance, requirement exercised
    half_tab = '{4000, 4000, 4000, 3960, 3960, 3960, 3883, 4000, 4124, 4000, 4000, 0, 0, 4000, 4000};
    wide_tab = '{0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 1, 1};
    req_tab  = '{"R9", "R5", "R5", "R6", "R4", "R4", "R4", "R6", "R6", "R5", "R7", "R8", "R8", "R8", "R5"};

    rec_half_ps = half_tab[0];
    wide_tol    = wide_tab[0];
    repeat (5) @(negedge ref_clk);
    check("R1", lock, 1'b0, "lock in reset");
    check("R1", track_sel, 1'b0, "track_sel in reset");
    rst_n = 1;

    while (win < NWIN) begin
      @(negedge ref_clk);
      cyc++;
      if (cyc % WIN == 0) begin
        bit good;
        good = (win == 0) ? 1'b0 : model_in_range(half_tab[win], wide_tab[win]);
        if (good) begin
          run++;
          exp_lock = (run >= 2);
        end else begin
          run = 0;
          exp_lock = 0;
        end
        check(req_tab[win], lock, exp_lock, "lock at window end");
        check("R7", track_sel, exp_lock, "track_sel at window end");
        win++;
        if (win < NWIN) begin
          rec_half_ps = half_tab[win];
          wide_tol    = wide_tab[win];
        end
      end else begin
        // R2: outputs only move at window ends
        check("R2", lock, exp_lock, "lock between windows");
        check("R7", track_sel, exp_lock, "track_sel between windows");
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge ref_clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule